// File: doc/BRIEF.md
# Conditional Rectangle Scan Dispatcher

This block walks a two-dimensional index rectangle on command and hands each surviving point to a processing element. For every point it fetches one stored value from a conditional buffer in memory. The buffer is laid out linearly from a programmable base address with a programmable row pitch. The block compares a programmed reference value against the fetched value using a selectable relation, and issues the point on a valid/ready dispatch port only when the relation holds. Points that fail the test are dropped silently and the scan moves on.

The rectangle corners, the test, the reference value, the base and the pitch are captured when a start command is accepted. A busy flag covers the whole run and feeds the idle detection that a wait-for-idle command relies on. A one-cycle done pulse marks the end of every run, including runs on an empty rectangle.

Top module: `condScanDispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy, done, rdReq and dispValid are all low.
- R2: Corners are inclusive. The points are visited in row-major order with x incrementing fastest: from (x0,y0) to (x1,y0), then on to row y0+1, ending at (x1,y1).
- R3: For each visited point exactly one read is issued: rdReq is high for a single cycle with rdAddr = base + y*pitch + x. No second read is issued before rdDataValid has returned the data for the current point.
- R4: The test code selects the relation "reference OP stored", with unsigned operands: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always.
- R5: A point is presented on dispValid/dispX/dispY only if its test passes, and only after its read data has arrived. dispValid, dispX and dispY hold steady until dispReady is seen high.
- R6: After a start is accepted on a non-empty rectangle, busy is high from the next cycle until the last point has been dispatched or skipped. In the cycle busy falls, done is high for exactly one cycle.
- R7: If x1 < x0 or y1 < y0, a start produces done in the next cycle and no reads or dispatches, and busy stays low.
- R8: A start command while busy is ignored. Changes to the configuration inputs during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCmd | input | 1 | Start a scan (taken only when idle) |
| domX0 | input | COORD_W | Left column, inclusive |
| domY0 | input | COORD_W | Top row, inclusive |
| domX1 | input | COORD_W | Right column, inclusive |
| domY1 | input | COORD_W | Bottom row, inclusive |
| testCode | input | 3 | Comparison selector (R4 encoding) |
| refVal | input | VAL_W | Reference value |
| bufBase | input | ADDR_W | Conditional buffer base address |
| bufPitch | input | PITCH_W | Buffer row pitch in elements |
| rdReq | output | 1 | Read request, one cycle per point |
| rdAddr | output | ADDR_W | Read address |
| rdDataValid | input | 1 | Read data valid |
| rdData | input | VAL_W | Stored conditional value |
| dispValid | output | 1 | Dispatch valid |
| dispReady | input | 1 | Dispatch accepted by the consumer |
| dispX | output | COORD_W | Dispatched column |
| dispY | output | COORD_W | Dispatched row |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A wrong position counter shows up at the read port right away. The next rdAddr after the fault is off by one element or by a whole pitch, so the address stream points to a mismatched element within one point's time. A wrong comparison or a mishandled dispatch handshake shows up as a missing, extra or repeated point in the dispatch stream. This is seen at the first handshake that follows. A wrong end condition shows up as busy and done disagreeing with the expected point count. It becomes visible as either a hung busy or leftover expected reads when done appears.

// File: rtl/scanPkg.sv
package scanPkg;

  typedef enum logic [2:0] {
    TST_NEVER  = 3'd0,
    TST_LT     = 3'd1,
    TST_EQ     = 3'd2,
    TST_LE     = 3'd3,
    TST_GT     = 3'd4,
    TST_NE     = 3'd5,
    TST_GE     = 3'd6,
    TST_ALWAYS = 3'd7
  } cmpCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic stepPt;
  } ctrlStrobe_t;

  // status flags from datapath to control
  typedef struct packed {
    logic domEmpty;
    logic lastPt;
    logic cmpPass;
  } dpStatus_t;

endpackage

// File: rtl/scanDatapath.sv
module scanDatapath
  import scanPkg::*;
#(
  parameter int COORD_W = 10,
  parameter int VAL_W   = 16,
  parameter int ADDR_W  = 24,
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [COORD_W-1:0] domX0,
  input  logic [COORD_W-1:0] domY0,
  input  logic [COORD_W-1:0] domX1,
  input  logic [COORD_W-1:0] domY1,
  input  logic [2:0]         testCode,
  input  logic [VAL_W-1:0]   refVal,
  input  logic [ADDR_W-1:0]  bufBase,
  input  logic [PITCH_W-1:0] bufPitch,
  input  logic [VAL_W-1:0]   rdData,
  output dpStatus_t          status,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY,
  output logic [ADDR_W-1:0]  rdAddr
);

  localparam int PROD_W = COORD_W + PITCH_W;

  logic [COORD_W-1:0] cfgX0, cfgX1, cfgY1;
  logic [VAL_W-1:0]   cfgRef;
  cmpCode_e           cfgTest;
  logic [ADDR_W-1:0]  cfgBase;
  logic [PITCH_W-1:0] cfgPitch;
  logic [PROD_W-1:0]  rowOff;
  logic               rowEnd;
  logic               cmpRes;

  // configuration capture and point stepping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgX0    <= '0;
      cfgX1    <= '0;
      cfgY1    <= '0;
      cfgRef   <= '0;
      cfgTest  <= TST_NEVER;
      cfgBase  <= '0;
      cfgPitch <= '0;
      curX     <= '0;
      curY     <= '0;
    end else if (strobe.loadCfg) begin
      cfgX0    <= domX0;
      cfgX1    <= domX1;
      cfgY1    <= domY1;
      cfgRef   <= refVal;
      cfgTest  <= cmpCode_e'(testCode);
      cfgBase  <= bufBase;
      cfgPitch <= bufPitch;
      curX     <= domX0;
      curY     <= domY0;
    end else if (strobe.stepPt) begin
      if (rowEnd) begin
        curX <= cfgX0;
        curY <= curY + COORD_W'(1);
      end else begin
        curX <= curX + COORD_W'(1);
      end
    end
  end

  assign rowEnd = (curX == cfgX1);

  // linear address of the current element
  assign rowOff = PROD_W'(curY) * PROD_W'(cfgPitch);
  assign rdAddr = cfgBase + ADDR_W'(rowOff) + ADDR_W'(curX);

  // reference OP stored
  always_comb begin
    unique case (cfgTest)
      TST_NEVER:  cmpRes = 1'b0;
      TST_LT:     cmpRes = (cfgRef <  rdData);
      TST_EQ:     cmpRes = (cfgRef == rdData);
      TST_LE:     cmpRes = (cfgRef <= rdData);
      TST_GT:     cmpRes = (cfgRef >  rdData);
      TST_NE:     cmpRes = (cfgRef != rdData);
      TST_GE:     cmpRes = (cfgRef >= rdData);
      TST_ALWAYS: cmpRes = 1'b1;
      default:    cmpRes = 1'b0;
    endcase
  end

  assign status.domEmpty = (domX1 < domX0) || (domY1 < domY0);
  assign status.lastPt   = rowEnd && (curY == cfgY1);
  assign status.cmpPass  = cmpRes;

  // a step never carries the row past the last configured row
  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepPt && !status.lastPt) |=> (curY <= cfgY1)); // R2

  // a row wrap returns to the left column
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepPt && rowEnd && !status.lastPt) |=> (curX == cfgX0)); // R2

endmodule

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  logic        rdDataValid,
  input  logic        dispReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        rdReq,
  output logic        dispValid,
  output logic        busy,
  output logic        done
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_DISP = 2'd3
  } scanState_e;

  scanState_e state, stateNext;
  logic       doneNext;

  always_comb begin
    stateNext      = state;
    doneNext       = 1'b0;
    strobe.loadCfg = 1'b0;
    strobe.stepPt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startCmd) begin
          if (status.domEmpty) begin
            doneNext = 1'b1;
          end else begin
            strobe.loadCfg = 1'b1;
            stateNext      = ST_READ;
          end
        end
      end
      ST_READ: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (rdDataValid) begin
          if (status.cmpPass) begin
            stateNext = ST_DISP;
          end else if (status.lastPt) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            strobe.stepPt = 1'b1;
            stateNext     = ST_READ;
          end
        end
      end
      ST_DISP: begin
        if (dispReady) begin
          if (status.lastPt) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            strobe.stepPt = 1'b1;
            stateNext     = ST_READ;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign rdReq     = (state == ST_READ);
  assign dispValid = (state == ST_DISP);
  assign busy      = (state != ST_IDLE);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R3

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady) |=> dispValid); // R5

  AST_DISP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispValid) |-> $past(rdDataValid)); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy && status.domEmpty) |=> (!busy && done)); // R7

  AST_START_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy && !status.domEmpty) |=> (busy && rdReq)); // R6

endmodule

// File: rtl/condScanDispatch.sv
module condScanDispatch
  import scanPkg::*;
#(
  parameter int COORD_W = 10,
  parameter int VAL_W   = 16,
  parameter int ADDR_W  = 24,
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startCmd,
  input  logic [COORD_W-1:0] domX0,
  input  logic [COORD_W-1:0] domY0,
  input  logic [COORD_W-1:0] domX1,
  input  logic [COORD_W-1:0] domY1,
  input  logic [2:0]         testCode,
  input  logic [VAL_W-1:0]   refVal,
  input  logic [ADDR_W-1:0]  bufBase,
  input  logic [PITCH_W-1:0] bufPitch,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdDataValid,
  input  logic [VAL_W-1:0]   rdData,
  output logic               dispValid,
  input  logic               dispReady,
  output logic [COORD_W-1:0] dispX,
  output logic [COORD_W-1:0] dispY,
  output logic               busy,
  output logic               done
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  scanCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startCmd    (startCmd),
    .rdDataValid (rdDataValid),
    .dispReady   (dispReady),
    .status      (status),
    .strobe      (strobe),
    .rdReq       (rdReq),
    .dispValid   (dispValid),
    .busy        (busy),
    .done        (done)
  );

  scanDatapath #(
    .COORD_W (COORD_W),
    .VAL_W   (VAL_W),
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .domX0    (domX0),
    .domY0    (domY0),
    .domX1    (domX1),
    .domY1    (domY1),
    .testCode (testCode),
    .refVal   (refVal),
    .bufBase  (bufBase),
    .bufPitch (bufPitch),
    .rdData   (rdData),
    .status   (status),
    .curX     (dispX),
    .curY     (dispY),
    .rdAddr   (rdAddr)
  );

  AST_DISP_XY_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady) |=> ($stable(dispX) && $stable(dispY))); // R5

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || dispValid) |-> busy); // R6

endmodule

// File: tb/condScanDispatch_bench.sv
module condScanDispatch_bench;

  localparam int COORD_W = 10;
  localparam int VAL_W   = 16;
  localparam int ADDR_W  = 24;
  localparam int PITCH_W = 12;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               startCmd = 1'b0;
  logic [COORD_W-1:0] domX0 = '0, domY0 = '0, domX1 = '0, domY1 = '0;
  logic [2:0]         testCode = '0;
  logic [VAL_W-1:0]   refVal = '0;
  logic [ADDR_W-1:0]  bufBase = '0;
  logic [PITCH_W-1:0] bufPitch = '0;
  logic               rdReq;
  logic [ADDR_W-1:0]  rdAddr;
  logic               rdDataValid = 1'b0;
  logic [VAL_W-1:0]   rdData = '0;
  logic               dispValid;
  logic               dispReady = 1'b0;
  logic [COORD_W-1:0] dispX, dispY;
  logic               busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  condScanDispatch #(
    .COORD_W (COORD_W), .VAL_W (VAL_W), .ADDR_W (ADDR_W), .PITCH_W (PITCH_W)
  ) u_condScanDispatch (
    .clk (clk), .rstN (rstN), .startCmd (startCmd),
    .domX0 (domX0), .domY0 (domY0), .domX1 (domX1), .domY1 (domY1),
    .testCode (testCode), .refVal (refVal), .bufBase (bufBase), .bufPitch (bufPitch),
    .rdReq (rdReq), .rdAddr (rdAddr), .rdDataValid (rdDataValid), .rdData (rdData),
    .dispValid (dispValid), .dispReady (dispReady), .dispX (dispX), .dispY (dispY),
    .busy (busy), .done (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int memVal(input int addr);
    return (addr * 7 + 3) % 16;
  endfunction

  function automatic bit passes(input int code, input int r, input int s);
    case (code)
      0: return 1'b0;
      1: return r < s;
      2: return r == s;
      3: return r <= s;
      4: return r > s;
      5: return r != s;
      6: return r >= s;
      default: return 1'b1;
    endcase
  endfunction

  task automatic runScan(input int x0, input int y0, input int x1, input int y1,
                         input int code, input int rv, input int base, input int pitch,
                         input int readyMode, input int injectAt);
    int expAddr[$];
    int expX[$];
    int expY[$];
    int pend = 0;
    int pendData = 0;
    int iter = 0;
    bit stalled = 1'b0;
    int sx = 0;
    int sy = 0;
    bit emptyDom;
    emptyDom = (x1 < x0) || (y1 < y0);
    if (!emptyDom) begin
      for (int y = y0; y <= y1; y++) begin
        for (int x = x0; x <= x1; x++) begin
          int a;
          a = base + y * pitch + x;
          expAddr.push_back(a);
          if (passes(code, rv, memVal(a))) begin
            expX.push_back(x);
            expY.push_back(y);
          end
        end
      end
    end
    @(negedge clk);
    domX0 = COORD_W'(x0); domY0 = COORD_W'(y0);
    domX1 = COORD_W'(x1); domY1 = COORD_W'(y1);
    testCode = 3'(code); refVal = VAL_W'(rv);
    bufBase = ADDR_W'(base); bufPitch = PITCH_W'(pitch);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    if (emptyDom) begin
      check(done == 1'b1, "R7 done after empty start", int'(done), 1);
      check(busy == 1'b0, "R7 busy stays low", int'(busy), 0);
      check(rdReq == 1'b0 && dispValid == 1'b0, "R7 no read or dispatch",
            int'(rdReq) + int'(dispValid), 0);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R7 done is one pulse", int'(done), 0);
      return;
    end
    while (1) begin
      rdDataValid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rdDataValid = 1'b1;
          rdData = VAL_W'(pendData);
        end
      end
      if (done) begin
        check(busy == 1'b0, "R6 busy low with done", int'(busy), 0);
        check(expAddr.size() == 0, "R2 all points read before done", expAddr.size(), 0);
        check(expX.size() == 0, "R5 all passing points dispatched", expX.size(), 0);
        check(rdReq == 1'b0 && dispValid == 1'b0, "R6 quiet at done",
              int'(rdReq) + int'(dispValid), 0);
        break;
      end
      check(busy == 1'b1, "R6 busy during run", int'(busy), 1);
      if (stalled) begin
        check(dispValid == 1'b1, "R5 valid held while stalled", int'(dispValid), 1);
        check(int'(dispX) == sx && int'(dispY) == sy, "R5 point held while stalled",
              int'(dispX) * 1000 + int'(dispY), sx * 1000 + sy);
      end
      if (rdReq) begin
        check(pend == 0 && !rdDataValid, "R3 no read while one is pending", pend, 0);
        if (expAddr.size() == 0) begin
          check(1'b0, "R3 unexpected extra read", int'(rdAddr), -1);
        end else begin
          int ea;
          ea = expAddr.pop_front();
          check(int'(rdAddr) == ea, "R3 R2 read address order", int'(rdAddr), ea);
        end
        pendData = memVal(int'(rdAddr));
        pend = (iter % 3) + 1;
      end
      dispReady = (readyMode == 0) ? 1'b1 : ((iter % 3) != 1);
      if (dispValid && dispReady) begin
        stalled = 1'b0;
        if (expX.size() == 0) begin
          check(1'b0, "R4 R5 dispatch of failing point",
                int'(dispX) * 1000 + int'(dispY), -1);
        end else begin
          int ex;
          int ey;
          ex = expX.pop_front();
          ey = expY.pop_front();
          check(int'(dispX) == ex && int'(dispY) == ey, "R4 R5 dispatched point",
                int'(dispX) * 1000 + int'(dispY), ex * 1000 + ey);
        end
      end else if (dispValid) begin
        stalled = 1'b1;
        sx = int'(dispX);
        sy = int'(dispY);
      end else begin
        stalled = 1'b0;
      end
      if (iter == injectAt) begin
        startCmd = 1'b1;
        domX0 = '0; domY0 = '0; domX1 = COORD_W'(9); domY1 = COORD_W'(9);
        testCode = 3'd0; refVal = '0; bufBase = ADDR_W'(77); bufPitch = PITCH_W'(3);
      end else begin
        startCmd = 1'b0;
      end
      iter++;
      if (iter > 3000) begin
        check(1'b0, "R6 run did not finish", iter, 3000);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    rdDataValid = 1'b0;
    dispReady = 1'b0;
    startCmd = 1'b0;
    check(done == 1'b0, "R6 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && rdReq == 0 && dispValid == 0, "R1 state in reset",
          int'(busy) + int'(done) + int'(rdReq) + int'(dispValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && rdReq == 0 && dispValid == 0, "R1 state after reset",
          int'(busy) + int'(done) + int'(rdReq) + int'(dispValid), 0);
    // R2 R4 basic run, less-than, consumer always ready
    runScan(2, 1, 5, 3, 1, 8, 256, 16, 0, -1);
    // R4 every test code, consumer with backpressure
    for (int c = 0; c < 8; c++) begin
      runScan(3, 2, 6, 3, c, 8, 64, 20, 1, -1);
    end
    // R2 single point rectangle
    runScan(7, 7, 7, 7, 7, 0, 5, 10, 1, -1);
    // R7 empty in x, then empty in y
    runScan(5, 0, 4, 3, 7, 0, 0, 8, 0, -1);
    runScan(0, 5, 3, 4, 7, 0, 0, 8, 0, -1);
    // R8 start and new configuration while busy
    runScan(0, 0, 3, 2, 7, 0, 32, 4, 1, 4);
    // R3 wide pitch and base, greater-or-equal
    runScan(0, 0, 15, 7, 6, 5, 4096, 300, 1, -1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule